// File: doc/BRIEF.md
# SDRAM Column Data Path

This block sits between a command scheduler and the 16-bit data pins of an SDRAM. The scheduler presents column commands one per clock: a read, a write, or a burst stop. For a read, the block counts out the programmed number of column beats. It delays each beat by the programmed CAS latency and samples the data pins at the clock edge where that word is valid. Each captured word comes out with a one-cycle valid strobe, and the final word of every burst also carries an end-of-burst flag.

For a write, the block drives one word per beat onto the pins with an output enable. The user supplies the first word together with the command. After that, the block raises a pending flag for each further word it will take at the next edge. If single-location write mode is set, a write moves exactly one word, while reads keep the full burst length. A new column command of either kind, or a stop request, cuts any burst in progress. Several reads can be in flight at once, because the latency pipeline holds one bit per issued beat.

Top module: `sdr_col_datapath`

## Requirements
- R1: For a read command sampled at edge n with `cfg_lat` = m (1, 2 or 3), word k is the value of `dq_in` at edge n+m+k. It appears on `rd_data`, with `rd_valid` high, in the cycle after that edge. The bus value at edge n+m+k−1 is never captured for that word.
- R2: An uncut read returns exactly L words on consecutive cycles. `cfg_burst` codes 0, 1, 2 and 3 give L = 1, 2, 4 and 8, code 7 gives a full page of 256 words, and any other code gives 1.
- R3: Column commands are accepted on every clock. A read, a write or a stop that arrives while a burst is still issuing ends that burst: no further beats of it are issued, and beats already issued are still delivered.
- R4: `rd_last` is high for one cycle, together with `rd_valid`, on the final delivered word of each read burst, including a burst that was cut short. It is never high without `rd_valid`.
- R5: A write command sampled at edge n drives `wr_data` from edge n+k onto `dq_out`, with `dq_oe` high, in the cycle after edge n+k, for each beat k of the write length. `wr_pend` is high after edge e exactly when the block will consume another write word at edge e+1 unless a new command or a stop arrives. `dq_oe` is low whenever no write beat is being driven.
- R6: When `cfg_wr_single` is 1, a write drives exactly one word and leaves `wr_pend` low, while reads still return the full burst length.
- R7: `cmd_term` (with `cmd_valid` low) stops the burst in progress at that edge. When no burst is issuing, it has no visible effect on any output.
- R8: `cfg_err` is high in the cycle after an edge where `cfg_lat` is 0, or where `cfg_lat` is 2 while `cfg_fast` (clock above the latency-2 speed limit) is 1. Otherwise it is low.
- R9: While `rst` is high, `rd_valid`, `rd_last`, `dq_oe`, `wr_pend` and `cfg_err` are low after every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lat | input | 2 | CAS latency in clocks (1 to 3) |
| cfg_burst | input | 3 | Burst length code |
| cfg_wr_single | input | 1 | 1 = writes move one word only |
| cfg_fast | input | 1 | Clock is above the latency-2 limit |
| cmd_valid | input | 1 | Column command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read (with `cmd_valid`) |
| cmd_term | input | 1 | Stop the current burst |
| wr_data | input | 16 | Write word for the current beat |
| wr_pend | output | 1 | Another write word is taken at the next edge |
| dq_in | input | 16 | Data pins, input side |
| dq_out | output | 16 | Data pins, output side |
| dq_oe | output | 1 | Data pin output enable |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | 16 | Captured read word |
| rd_last | output | 1 | Final word of a read burst |
| cfg_err | output | 1 | Latency setting not allowed at this clock |

## Verification
The bench sweeps every latency with burst codes 0 to 3 and both write modes. It runs two command patterns for each setting. The first pattern is an isolated read and write, which pins down the exact capture edge and the burst length. The second has reads on consecutive clocks, a stop inside a burst, a stop while idle, and writes cut by writes. This shows whether truncation, end-of-burst marking and the pending-write flag follow the cut point rather than the programmed length. The data pins carry a value that encodes the edge number, so a word taken one edge early or late shows up as a wrong value. Full-page reads and writes, and the configuration-error table, are checked as separate cases.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

  // Number of column beats for a burst code; reserved codes fall back to one.
  function automatic int unsigned burst_words(input logic [2:0] code,
                                              input int unsigned page);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      3'd7:    return page;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/sdr_beat_seq.sv
module sdr_beat_seq #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [CW-1:0] len,
  output logic          issue,
  output logic [CW-1:0] remain
);

  logic busy;
  assign busy  = remain != '0;
  // A start always issues; an active burst issues unless cut this cycle.
  assign issue = start | (busy & ~stop);

  always_ff @(posedge clk) begin
    if (rst)        remain <= '0;
    else if (start) remain <= len - CW'(1);
    else if (stop)  remain <= '0;
    else if (busy)  remain <= remain - CW'(1);
  end

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int DW      = 16,
  parameter int MAX_LAT = 3,
  parameter int LW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] lat,
  input  logic          issue,
  input  logic          issue_last,
  input  logic          cut,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [DW-1:0] rd_data
);

  // One valid bit and one last bit per stage; stage i holds beats issued i edges ago.
  logic [MAX_LAT:1] pv, pl;
  logic             l1, tap_v, tap_l;

  // A cut marks the beat issued one edge earlier as the burst end.
  assign l1 = pl[1] | cut;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= '0;
      pl <= '0;
    end else begin
      pv[1] <= issue;
      pl[1] <= issue_last;
      for (int i = 2; i <= MAX_LAT; i++) begin
        pv[i] <= pv[i-1];
        pl[i] <= (i == 2) ? l1 : pl[i-1];
      end
    end
  end

  always_comb begin
    tap_v = 1'b0;
    tap_l = 1'b0;
    for (int i = 1; i <= MAX_LAT; i++) begin
      if (int'(lat) == i) begin
        tap_v = pv[i];
        tap_l = (i == 1) ? l1 : pl[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= tap_v;
      rd_last  <= tap_v & tap_l;
      if (tap_v) rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/sdr_wr_drive.sv
module sdr_wr_drive #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe <= issue;
      if (issue) dq_out <= wr_data;
    end
  end

endmodule

// File: rtl/sdr_col_datapath.sv
module sdr_col_datapath
  import sdr_dp_pkg::*;
#(
  parameter  int DW         = 16,
  parameter  int PAGE_WORDS = 256,
  parameter  int MAX_LAT    = 3,
  localparam int LW         = $clog2(MAX_LAT + 1),
  localparam int CW         = $clog2(PAGE_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] cfg_lat,
  input  logic [2:0]    cfg_burst,
  input  logic          cfg_wr_single,
  input  logic          cfg_fast,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic          cmd_term,
  input  logic [DW-1:0] wr_data,
  output logic          wr_pend,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          cfg_err
);

  logic [CW-1:0] rd_len, wr_len, rd_remain, wr_remain;
  logic          rd_start, wr_start, any_stop;
  logic          rd_issue, wr_issue, rd_issue_last, rd_cut;

  assign rd_len   = CW'(burst_words(cfg_burst, PAGE_WORDS));
  assign wr_len   = cfg_wr_single ? CW'(1) : rd_len;
  assign rd_start = cmd_valid & ~cmd_write;
  assign wr_start = cmd_valid &  cmd_write;
  assign any_stop = cmd_valid | cmd_term;

  sdr_beat_seq #(.CW(CW)) u_rd_seq (
    .clk(clk), .rst(rst), .start(rd_start), .stop(any_stop),
    .len(rd_len), .issue(rd_issue), .remain(rd_remain)
  );

  sdr_beat_seq #(.CW(CW)) u_wr_seq (
    .clk(clk), .rst(rst), .start(wr_start), .stop(any_stop),
    .len(wr_len), .issue(wr_issue), .remain(wr_remain)
  );

  assign rd_issue_last = rd_start ? (rd_len == CW'(1)) : (rd_remain == CW'(1));
  assign rd_cut        = (rd_remain != '0) & any_stop;
  assign wr_pend       = wr_remain != '0;

  sdr_rd_capture #(.DW(DW), .MAX_LAT(MAX_LAT), .LW(LW)) u_capture (
    .clk(clk), .rst(rst), .lat(cfg_lat), .issue(rd_issue),
    .issue_last(rd_issue_last), .cut(rd_cut), .dq_in(dq_in),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data)
  );

  sdr_wr_drive #(.DW(DW)) u_wr_drive (
    .clk(clk), .rst(rst), .issue(wr_issue), .wr_data(wr_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= (cfg_lat == '0) | (cfg_fast & (cfg_lat == LW'(2)));
  end

endmodule

// File: rtl/sdr_col_datapath_chk.sv
module sdr_col_datapath_chk #(
  parameter int DW = 16,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [LW-1:0] cfg_lat,
  input logic          cfg_wr_single,
  input logic          cfg_fast,
  input logic          cmd_valid,
  input logic          cmd_write,
  input logic          cmd_term,
  input logic [DW-1:0] wr_data,
  input logic          wr_pend,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic          rd_valid,
  input logic          rd_last,
  input logic          cfg_err
);

  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);

  a_r5_write_drives: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write) |=> (dq_oe && dq_out == $past(wr_data)));

  a_r5_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!wr_pend && !(cmd_valid && cmd_write)) |=> !dq_oe);

  a_r6_single_write: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write && cfg_wr_single) |=> !wr_pend);

  a_r7_term_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_term && !cmd_valid) |=> !wr_pend);

  a_r8_slow_latency_err: assert property (@(posedge clk) disable iff (rst)
    (cfg_fast && cfg_lat == LW'(2)) |=> cfg_err);

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_valid && !rd_last && !dq_oe && !wr_pend && !cfg_err));

endmodule

bind sdr_col_datapath sdr_col_datapath_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .cfg_lat(cfg_lat), .cfg_wr_single(cfg_wr_single),
  .cfg_fast(cfg_fast), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_term(cmd_term), .wr_data(wr_data), .wr_pend(wr_pend),
  .dq_out(dq_out), .dq_oe(dq_oe), .rd_valid(rd_valid), .rd_last(rd_last),
  .cfg_err(cfg_err)
);

// File: tb/test_sdr_col_datapath.sv
module test_sdr_col_datapath;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_lat = 2'd3;
  logic [2:0]  cfg_burst = 3'd0;
  logic        cfg_wr_single = 1'b0;
  logic        cfg_fast = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_term = 1'b0;
  logic [15:0] wr_data = '0, dq_in = '0;
  logic        wr_pend, dq_oe, rd_valid, rd_last, cfg_err;
  logic [15:0] dq_out, rd_data;

  always #2 clk = ~clk;

  sdr_col_datapath i_sdr_col_datapath (
    .clk(clk), .rst(rst), .cfg_lat(cfg_lat), .cfg_burst(cfg_burst),
    .cfg_wr_single(cfg_wr_single), .cfg_fast(cfg_fast),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_term(cmd_term),
    .wr_data(wr_data), .wr_pend(wr_pend), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .cfg_err(cfg_err)
  );

  localparam int NMAX = 640;
  int kind [NMAX];   // 0 idle, 1 read, 2 write, 3 stop
  bit ev [NMAX];
  bit el [NMAX];
  bit wo [NMAX];
  bit wp [NMAX];
  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string scn,
                       input int idx, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] cycle %0d actual=%0h expected=%0h", req, scn, idx, act, exp);
    end
  endtask

  task automatic clear_cmds();
    for (int i = 0; i < NMAX; i++) kind[i] = 0;
  endtask

  // Entered at a falling edge; item idx is sampled at the idx-th rising edge.
  task automatic run_scn(input int n, input int lat, input int bl,
                         input int wbl, input string name);
    for (int e = 0; e < NMAX; e++) begin
      ev[e] = 0; el[e] = 0; wo[e] = 0; wp[e] = 0;
    end
    for (int i = 0; i < n; i++) begin
      if (kind[i] == 1 || kind[i] == 2) begin
        int j, len, nb;
        j = i + 1;
        while (j < n && kind[j] == 0) j++;
        if (j >= n) j = 100000;
        len = (kind[i] == 1) ? bl : wbl;
        nb = (len < j - i) ? len : j - i;
        if (kind[i] == 1) begin
          for (int k = 0; k < nb; k++)
            if (i + lat + k < NMAX) ev[i + lat + k] = 1;
          if (i + lat + nb - 1 < NMAX) el[i + lat + nb - 1] = 1;
        end else begin
          for (int k = 0; k < nb; k++) wo[i + k] = 1;
          for (int e = i; e <= i + wbl - 2 && e < j; e++) wp[e] = 1;
        end
      end
    end
    for (int idx = 0; idx < n; idx++) begin
      cmd_valid = (kind[idx] == 1 || kind[idx] == 2);
      cmd_write = (kind[idx] == 2);
      cmd_term  = (kind[idx] == 3);
      dq_in     = 16'(32'h1000 + idx);
      wr_data   = 16'(32'h8000 + idx);
      @(posedge clk);
      #1;
      check(rd_valid == ev[idx], "R2", name, idx, int'(rd_valid), int'(ev[idx]));
      if (ev[idx])
        check(rd_data == 16'(32'h1000 + idx), "R1", name, idx, int'(rd_data), 32'h1000 + idx);
      check(rd_last == (ev[idx] & el[idx]), "R4", name, idx, int'(rd_last), int'(ev[idx] & el[idx]));
      check(dq_oe == wo[idx], (wbl == 1 && bl > 1) ? "R6" : "R5", name, idx, int'(dq_oe), int'(wo[idx]));
      if (wo[idx])
        check(dq_out == 16'(32'h8000 + idx), "R5", name, idx, int'(dq_out), 32'h8000 + idx);
      check(wr_pend == wp[idx], "R5", name, idx, int'(wr_pend), int'(wp[idx]));
      @(negedge clk);
    end
    cmd_valid = 0; cmd_write = 0; cmd_term = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R9: quiet outputs during reset
    repeat (4) begin
      @(posedge clk); #1;
      check(!rd_valid && !rd_last && !dq_oe && !wr_pend && !cfg_err, "R9", "reset", 0,
            int'({rd_valid, rd_last, dq_oe, wr_pend, cfg_err}), 0);
    end
    @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R8: configuration error table
    for (int l = 0; l < 4; l++) begin
      for (int f = 0; f < 2; f++) begin
        cfg_lat = 2'(l);
        cfg_fast = f[0];
        @(posedge clk); #1;
        check(cfg_err == ((l == 0) || (f == 1 && l == 2)), "R8", "cfg", l * 2 + f,
              int'(cfg_err), int'((l == 0) || (f == 1 && l == 2)));
        @(negedge clk);
      end
    end
    cfg_fast = 0;

    // Sweep latency, burst code and write mode
    for (int lat = 1; lat <= 3; lat++) begin
      for (int code = 0; code < 4; code++) begin
        for (int s = 0; s < 2; s++) begin
          int bl, wbl;
          cfg_lat = 2'(lat);
          cfg_burst = 3'(code);
          cfg_wr_single = s[0];
          bl = 1 << code;
          wbl = (s == 1) ? 1 : bl;
          @(negedge clk);
          clear_cmds();
          kind[0] = 1;
          kind[20] = 2;
          run_scn(50, lat, bl, wbl, "R1 R2 isolated read/write");
          clear_cmds();
          kind[0] = 1; kind[1] = 1; kind[2] = 1; kind[5] = 1;
          kind[7] = 3; kind[12] = 3;
          kind[16] = 2; kind[17] = 2; kind[20] = 2; kind[22] = 3;
          kind[30] = 1;
          run_scn(60, lat, bl, wbl, "R3 R7 back-to-back and stop");
        end
      end
    end

    // Full-page bursts
    for (int lat = 2; lat <= 3; lat++) begin
      for (int s = 0; s < 2; s++) begin
        cfg_lat = 2'(lat);
        cfg_burst = 3'd7;
        cfg_wr_single = s[0];
        @(negedge clk);
        clear_cmds();
        kind[0] = 1; kind[270] = 2; kind[540] = 1; kind[560] = 3;
        run_scn(600, lat, 256, (s == 1) ? 1 : 256, "R2 R6 full page");
      end
    end

    summary();
    $finish;
  end

endmodule